// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Aggregator

This block gathers sixteen level-sensitive interrupt requests from local-bus peripherals into a single interrupt line for the processor. Each request input is brought into the clock domain through a short synchroniser chain. The last stage of that chain is the source register, so each bit mirrors the current level of its request. A sixteen-bit enable mask decides which sources are allowed to count. Sources that are both raised and enabled form the pending set. The output line is the registered OR of that set.

Software uses a byte-wide register window. A read at offset 0x00 returns a vector that identifies the lowest-numbered pending source, so a handler can dispatch without scanning a bitmap. The enable mask is written one byte lane at a time. Wider processor accesses are split into consecutive byte accesses, with the least significant byte at the lowest offset.

Top module: `lbus_irq_agg`

## Requirements
- R1: Each bit of the source register follows the level of its request input. An input level that is set up before clock edge k is in the source register after edge k+1.
- R2: `irq_out` is high exactly when (source register AND enable mask) is non-zero. It is registered, so it reflects the pending set one edge later.
- R3: A read at offset 0x00 returns (n+1)*4, where n is the lowest-numbered pending source. It returns 0 when nothing is pending. The read data is combinational from the current register state.
- R4: A write at offset 0x02 replaces mask bits 7:0 and keeps bits 15:8. A write at offset 0x03 replaces bits 15:8 and keeps bits 7:0.
- R5: A mask write at edge k changes the read vector right after edge k and `irq_out` after edge k+1.
- R6: Reads at any offset other than 0x00 return 0; this includes the mask lanes 0x02 and 0x03. Writes to any offset other than 0x02 and 0x03 leave the mask unchanged.
- R7: While reset is asserted, the source register and the mask are 0, `irq_out` is low and a read at 0x00 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 16 | Level-sensitive interrupt requests, bit i is source i |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_we | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Byte read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt line to the processor |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `bus_we`, `bus_addr` and `bus_wdata` are stable around each rising edge, so that exactly one byte lane changes per write strobe. The stimulus changes every input only on the falling edge. It keeps the write strobe to a single cycle and chooses offsets across the whole 8-bit range, so writes to unsupported offsets and to the two mask lanes are both exercised. The request inputs are treated as asynchronous levels, and the bench expects them only after the synchroniser delay.

// File: rtl/lbus_irq_agg.sv
module lbus_irq_agg #(
  parameter int N_SRC       = 16,
  parameter int OFF_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_OFF     = 0,
  parameter int MASK_OFF    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq_out
);
  localparam int LANES = (N_SRC + 7) / 8;

  logic [SYNC_STAGES-1:0][N_SRC-1:0] sync_q;
  logic [LANES*8-1:0]                mask_q;
  logic [N_SRC-1:0]                  src_q;
  logic [N_SRC-1:0]                  pending;
  logic [7:0]                        vec;

  assign src_q   = sync_q[SYNC_STAGES-1];
  assign pending = src_q & mask_q[N_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], src_lvl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (bus_we) begin
      for (int g = 0; g < LANES; g++)
        if (bus_addr == OFF_W'(MASK_OFF + g)) mask_q[g*8 +: 8] <= bus_wdata;
    end
  end

  always_comb begin
    vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pending[i]) vec = 8'((i + 1) * 4);
  end

  assign bus_rdata = (bus_addr == OFF_W'(VEC_OFF)) ? vec : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |pending;
  end

  AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vec == 8'h00)); // R3
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> (vec != 8'h00 && vec[1:0] == 2'b00)); // R3
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(mask_q) != '0)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == OFF_W'(MASK_OFF) || bus_addr == OFF_W'(MASK_OFF + 1)))
      |=> $stable(mask_q)); // R6
  AST_LOW_LANE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_W'(MASK_OFF))
      |=> (mask_q[15:8] == $past(mask_q[15:8]) && mask_q[7:0] == $past(bus_wdata))); // R4
  AST_RDATA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFF_W'(VEC_OFF)) |-> (bus_rdata == 8'h00)); // R6
endmodule

// File: tb/lbus_irq_agg_test.sv
module lbus_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_lvl = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] s1_m = '0, src_m = '0, mask_m = '0;
  logic        irq_m = 1'b0;

  always #2.5 clk = ~clk;

  lbus_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] ref_vec(logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 8'((i + 1) * 4);
    return 8'h00;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      s1_m = '0; src_m = '0; mask_m = '0; irq_m = 1'b0;
    end else begin
      irq_m = |(src_m & mask_m);
      src_m = s1_m;
      s1_m  = src_lvl;
      if (bus_we && bus_addr == 8'h02) mask_m[7:0]  = bus_wdata;
      if (bus_we && bus_addr == 8'h03) mask_m[15:8] = bus_wdata;
    end
    #2;
    if (rst_n) begin
      check("R2 irq model", irq_out, irq_m);
      if (bus_addr == 8'h00) check("R3 vector model", bus_rdata, ref_vec(src_m & mask_m));
      else                   check("R6 unsupported read model", bus_rdata, 0);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    while (!done && cycles < 100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual cycles %0d expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    src_lvl = 16'hFFFF;
    wait_cyc(4);
    #1;
    check("R7 irq in reset", irq_out, 0);
    check("R7 vector in reset", bus_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(4); #1;
    check("R2 masked sources keep irq low", irq_out, 0);
    check("R3 nothing enabled reads 0", bus_rdata, 0);

    @(negedge clk); bus_addr = 8'h02; bus_we = 1'b1; bus_wdata = 8'h10;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00; #1;
    check("R5 vector right after mask write", bus_rdata, 20);
    check("R5 irq not yet after mask write", irq_out, 0);
    @(negedge clk); #1;
    check("R5 irq one edge after mask write", irq_out, 1);

    wr(8'h03, 8'h80); #1;
    check("R4 high lane write keeps low lane", bus_rdata, 20);
    @(negedge clk); src_lvl = 16'hFFEF;
    @(negedge clk); #1;
    check("R1 source not yet updated after one edge", bus_rdata, 20);
    @(negedge clk); #1;
    check("R1 source follows level after two edges", bus_rdata, 64);
    wr(8'h02, 8'h00); #1;
    check("R4 low lane write keeps high lane", bus_rdata, 64);

    for (int a = 1; a < 256; a += 37) begin
      @(negedge clk); bus_addr = 8'(a); #1;
      check("R6 unsupported offset reads 0", bus_rdata, 0);
    end
    @(negedge clk); bus_addr = 8'h02; #1; check("R6 mask lane reads 0", bus_rdata, 0);
    @(negedge clk); bus_addr = 8'h03; #1; check("R6 mask lane reads 0", bus_rdata, 0);
    wr(8'h05, 8'hFF); wr(8'h01, 8'hFF); wr(8'h00, 8'hFF); #1;
    check("R6 ignored writes keep mask", bus_rdata, 64);

    @(negedge clk); src_lvl = 16'h0000;
    wait_cyc(3); #1;
    check("R1 sources cleared reads 0", bus_rdata, 0);
    @(negedge clk); #1;
    check("R2 irq falls when sources drop", irq_out, 0);

    wr(8'h02, 8'hFF); wr(8'h03, 8'hFF);
    @(negedge clk); src_lvl = 16'h8000;
    wait_cyc(4); #1;
    check("R3 top source vector", bus_rdata, 64);
    @(negedge clk); src_lvl = 16'h8001;
    wait_cyc(3); #1;
    check("R3 lowest index wins", bus_rdata, 4);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) src_lvl = 16'($urandom);
      bus_we    = ($urandom_range(0, 4) == 0);
      bus_wdata = 8'($urandom);
      case ($urandom_range(0, 5))
        0, 1: bus_addr = 8'h00;
        2:    bus_addr = 8'h02;
        3:    bus_addr = 8'h03;
        default: bus_addr = 8'($urandom);
      endcase
    end
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00;

    @(negedge clk); rst_n = 1'b0; #1;
    check("R7 irq after mid-run reset", irq_out, 0);
    check("R7 vector after mid-run reset", bus_rdata, 0);
    wait_cyc(2); rst_n = 1'b1;
    wait_cyc(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule